// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Fetch Unit

This block turns an 8-bit interrupt number into the physical address of its handler. It reads a four-byte table entry from memory and combines the two halves of that entry. The lower half is a 16-bit offset and the upper half is a 16-bit segment. The handler address is the segment scaled by sixteen plus the offset, which places every handler inside the first megabyte. The block reads memory through a simple request/acknowledge port that carries 16 bits per beat. It is started by a one-cycle strobe together with the interrupt number. It reports the result on a one-cycle done pulse, which comes with the segment, the offset and the 20-bit linear address.

The table holds 256 entries and sits at byte address zero after reset. It can be moved by loading a base register and shrunk by loading a limit register. The limit holds the byte index of the last valid table byte. Neither register changes the layout of an entry. Interrupt numbers 0 to 31 are normally used for processor exceptions, but the unit treats all 256 numbers the same way. An interrupt number whose entry does not fit under the limit produces a fault pulse and no memory traffic. Choosing which interrupt to serve is done outside this block.

Top module: `ivec_fetch`

## Requirements
- R1: After reset, `done`, `fault`, `busy` and `mem_req` are low, and `hnd_segment`, `hnd_offset` and `hnd_linear` are zero. The base register is 0x00000 and the limit register is 0x03FF, so all 256 entries are reachable.
- R2: A start accepted at the base in force at that edge reads the entry at byte address (base + vector×4) mod 2^20. It issues exactly two read beats. The first beat is at the entry address and returns the offset word. The second beat is at the entry address + 2 and returns the segment word. Entries are little-endian, so each 16-bit word has its low byte at the lower address.
- R3: `hnd_linear` equals (segment × 16 + offset) mod 2^20, and any carry out of bit 19 is dropped.
- R4: `done` is high for exactly one cycle, in the cycle after the segment beat is acknowledged. The three handler outputs change only in that cycle and otherwise hold their values.
- R5: When vector×4 + 3 is greater than the limit, `fault` pulses for one cycle in the cycle after the start. In that case no read is requested, no `done` is issued and the handler outputs keep their values. An entry whose last byte index equals the limit is fetched normally.
- R6: A start strobe that arrives while `busy` is high is ignored. The fetch in progress completes with its own vector, and exactly one `done` results.
- R7: Writes to the base or limit register apply to starts accepted after the write. A write made during a fetch does not change the addresses that fetch uses.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen. Any number of wait cycles is allowed before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 20 | New table base byte address |
| limit_we | input | 1 | Load the table limit register |
| limit_wdata | input | 16 | New limit (byte index of the last valid table byte) |
| start | input | 1 | Begin a fetch for `vector` (ignored while busy) |
| vector | input | 8 | Interrupt number |
| busy | output | 1 | A fetch is in progress |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 20 | Byte address of the requested 16-bit word |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 16 | Read data word |
| done | output | 1 | One-cycle pulse: handler outputs updated |
| fault | output | 1 | One-cycle pulse: entry lies past the limit |
| hnd_segment | output | 16 | Handler segment from the entry |
| hnd_offset | output | 16 | Handler offset from the entry |
| hnd_linear | output | 20 | Handler physical address |

## Verification
The fetch is exercised at the first, a middle and the last vector under the reset table. This separates a correct vector×4 scaling from an off-by-one, and checks that the offset word is read before the segment word. Entries whose segment and offset are both all ones force the 20-bit sum past bit 19, and a base near the top of memory forces the entry address to wrap. Those two cases show whether each adder drops its carry. The acknowledge latency is varied from zero to several cycles, which tells request holding apart from a fixed-timing assumption. A limit whose last allowed byte falls exactly on an entry boundary tells the inclusive comparison apart from an exclusive one.

// File: rtl/ivec_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the sequencer state type for the vector fetch unit.
// Assumes a byte-addressed 20-bit physical space and 16-bit read beats.
package ivec_pkg;
    localparam int IVEC_ADDR_W = 20;  // physical byte address width
    localparam int IVEC_DATA_W = 16;  // read beat width
    localparam int IVEC_VEC_W  = 8;   // interrupt number width
    localparam int IVEC_LIM_W  = 16;  // limit register width
    localparam int IVEC_SEG_SH = 4;   // segment scaling shift

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_OFF = 2'd1,
        ST_RD_SEG = 2'd2
    } ivec_state_e;
endpackage

// File: rtl/ivec_tbl_regs.sv
`timescale 1ns/1ps
// Module: holds the table base and limit registers.
// Assumes the writes come from a trusted configuration source; the two
// registers load independently, and a load takes effect on the next cycle.
module ivec_tbl_regs #(
    parameter int                  ADDR_W    = 20,
    parameter int                  LIM_W     = 16,
    parameter logic [LIM_W-1:0]    RST_LIMIT = 16'h03FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              limit_we,
    input  logic [LIM_W-1:0]  limit_wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [LIM_W-1:0]  limit_q
);
    // Load the base and limit registers; reset puts the table at address zero
    // with room for every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= RST_LIMIT;
        end else begin
            if (base_we)  base_q  <= base_wdata;
            if (limit_we) limit_q <= limit_wdata;
        end
    end
endmodule

// File: rtl/ivec_entry_calc.sv
`timescale 1ns/1ps
// Module: forms the entry byte address and the bounds verdict for a vector.
// Purely combinational. Assumes each entry is 2**ENTRY_SH bytes long. The
// address wraps modulo 2**ADDR_W, and the bounds test is inclusive of the limit.
module ivec_entry_calc #(
    parameter int ADDR_W   = 20,
    parameter int VEC_W    = 8,
    parameter int LIM_W    = 16,
    parameter int ENTRY_SH = 2
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              out_of_range
);
    localparam int IDX_W = VEC_W + ENTRY_SH;
    localparam int CMP_W = (IDX_W > LIM_W) ? IDX_W : LIM_W;
    localparam logic [IDX_W-1:0] LOW_MASK = IDX_W'((1 << ENTRY_SH) - 1);

    logic [IDX_W-1:0] idx_first;
    logic [IDX_W-1:0] idx_last;

    // Scale the vector to a byte index, then locate the entry's last byte.
    always_comb begin
        idx_first = {vec, {ENTRY_SH{1'b0}}};
        idx_last  = idx_first | LOW_MASK;
    end

    // Add the scaled index to the base; the carry out of the top bit is dropped.
    always_comb begin
        entry_addr = base + ADDR_W'(idx_first);
    end

    // Compare the last byte index against the limit in a width that holds both.
    always_comb begin
        out_of_range = CMP_W'(idx_last) > CMP_W'(limit);
    end
endmodule

// File: rtl/ivec_linear.sv
`timescale 1ns/1ps
// Module: converts a segment:offset pair to a physical address.
// Purely combinational. The segment is shifted left by SEG_SH and the offset
// is added; the sum is truncated to ADDR_W bits.
module ivec_linear #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_SH = 4
) (
    input  logic [DATA_W-1:0] seg,
    input  logic [DATA_W-1:0] off,
    output logic [ADDR_W-1:0] lin
);
    localparam int SCALED_W = DATA_W + SEG_SH;

    logic [SCALED_W-1:0] seg_scaled;

    // Scale the segment, then add the offset modulo 2**ADDR_W.
    always_comb begin
        seg_scaled = {seg, {SEG_SH{1'b0}}};
        lin        = ADDR_W'(seg_scaled) + ADDR_W'(off);
    end
endmodule

// File: rtl/ivec_fetch_ctrl.sv
`timescale 1ns/1ps
// Module: sequences the two read beats of one table entry and publishes the result.
// Assumes the memory side holds the acknowledge for a single cycle per beat.
// The entry address and the bounds verdict are sampled when the start is
// accepted, so later register loads do not disturb a fetch in flight.
module ivec_fetch_ctrl
    import ivec_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] entry_addr,
    input  logic              out_of_range,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] lin_in,
    output logic [DATA_W-1:0] off_tmp,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [DATA_W-1:0] hnd_segment,
    output logic [DATA_W-1:0] hnd_offset,
    output logic [ADDR_W-1:0] hnd_linear
);
    localparam int BEAT_BYTES = DATA_W / 8;

    ivec_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;

    // Advance the sequencer, capture beats, and raise the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            off_tmp     <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            hnd_segment <= '0;
            hnd_offset  <= '0;
            hnd_linear  <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (out_of_range) begin
                            fault <= 1'b1;
                        end else begin
                            addr_q  <= entry_addr;
                            state_q <= ST_RD_OFF;
                        end
                    end
                end
                ST_RD_OFF: begin
                    if (mem_ack) begin
                        off_tmp <= mem_rdata;
                        addr_q  <= addr_q + ADDR_W'(BEAT_BYTES);
                        state_q <= ST_RD_SEG;
                    end
                end
                ST_RD_SEG: begin
                    if (mem_ack) begin
                        hnd_segment <= mem_rdata;
                        hnd_offset  <= off_tmp;
                        hnd_linear  <= lin_in;
                        done        <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request memory in both read states; the address register drives the port.
    always_comb begin
        mem_req  = (state_q == ST_RD_OFF) || (state_q == ST_RD_SEG);
        busy     = (state_q != ST_IDLE);
        mem_addr = addr_q;
    end
endmodule

// File: rtl/ivec_fetch.sv
`timescale 1ns/1ps
// Module: top of the real-mode interrupt vector fetch unit.
// Wires the table registers, the entry address and bounds logic, the
// segment:offset converter and the beat sequencer together.
module ivec_fetch
    import ivec_pkg::*;
#(
    parameter int               ADDR_W    = IVEC_ADDR_W,
    parameter int               DATA_W    = IVEC_DATA_W,
    parameter int               VEC_W     = IVEC_VEC_W,
    parameter int               LIM_W     = IVEC_LIM_W,
    parameter int               SEG_SH    = IVEC_SEG_SH,
    parameter logic [LIM_W-1:0] RST_LIMIT = 16'h03FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              limit_we,
    input  logic [LIM_W-1:0]  limit_wdata,
    input  logic              start,
    input  logic [VEC_W-1:0]  vector,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [DATA_W-1:0] hnd_segment,
    output logic [DATA_W-1:0] hnd_offset,
    output logic [ADDR_W-1:0] hnd_linear
);
    localparam int WORDS_PER_ENTRY = 2;
    localparam int ENTRY_BYTES     = WORDS_PER_ENTRY * (DATA_W / 8);
    localparam int ENTRY_SH        = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] base_q;
    logic [LIM_W-1:0]  limit_q;
    logic [ADDR_W-1:0] entry_addr;
    logic              out_of_range;
    logic [DATA_W-1:0] off_tmp;
    logic [ADDR_W-1:0] lin_w;

    ivec_tbl_regs #(
        .ADDR_W    (ADDR_W),
        .LIM_W     (LIM_W),
        .RST_LIMIT (RST_LIMIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_we     (base_we),
        .base_wdata  (base_wdata),
        .limit_we    (limit_we),
        .limit_wdata (limit_wdata),
        .base_q      (base_q),
        .limit_q     (limit_q)
    );

    ivec_entry_calc #(
        .ADDR_W   (ADDR_W),
        .VEC_W    (VEC_W),
        .LIM_W    (LIM_W),
        .ENTRY_SH (ENTRY_SH)
    ) u_calc (
        .vec          (vector),
        .base         (base_q),
        .limit        (limit_q),
        .entry_addr   (entry_addr),
        .out_of_range (out_of_range)
    );

    ivec_linear #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEG_SH (SEG_SH)
    ) u_lin (
        .seg (mem_rdata),
        .off (off_tmp),
        .lin (lin_w)
    );

    ivec_fetch_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .entry_addr   (entry_addr),
        .out_of_range (out_of_range),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .lin_in       (lin_w),
        .off_tmp      (off_tmp),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .busy         (busy),
        .done         (done),
        .fault        (fault),
        .hnd_segment  (hnd_segment),
        .hnd_offset   (hnd_offset),
        .hnd_linear   (hnd_linear)
    );
endmodule

// File: rtl/ivec_fetch_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the vector fetch unit, observed at its ports.
module ivec_fetch_chk
    import ivec_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   mem_req,
    input logic [IVEC_ADDR_W-1:0] mem_addr,
    input logic                   mem_ack,
    input logic                   done,
    input logic                   fault,
    input logic [IVEC_DATA_W-1:0] hnd_segment,
    input logic [IVEC_DATA_W-1:0] hnd_offset,
    input logic [IVEC_ADDR_W-1:0] hnd_linear
);
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!done && !busy));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || (mem_addr == $past(mem_addr) + IVEC_ADDR_W'(2))));

    assert_req_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(start));

    assert_linear_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hnd_linear == (IVEC_ADDR_W'({hnd_segment, 4'b0000}) + IVEC_ADDR_W'(hnd_offset))));
endmodule

bind ivec_fetch ivec_fetch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .done        (done),
    .fault       (fault),
    .hnd_segment (hnd_segment),
    .hnd_offset  (hnd_offset),
    .hnd_linear  (hnd_linear)
);

// File: tb/ivec_fetch_test.sv
`timescale 1ns/1ps
module ivec_fetch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [19:0] base_wdata = '0;
    logic        limit_we = 1'b0;
    logic [15:0] limit_wdata = '0;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic        busy;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic        fault;
    logic [15:0] hnd_segment;
    logic [15:0] hnd_offset;
    logic [19:0] hnd_linear;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;
    int lat = 0;
    int wait_cnt = 0;
    logic [19:0] log_addr [8];
    int log_n = 0;
    int done_cnt = 0;
    logic [15:0] ovr [logic [19:0]];

    ivec_fetch uut (.*);

    always #4 clk = ~clk;

    // Memory contents: programmed words first, otherwise a fixed pattern of the address.
    function automatic logic [15:0] mdl(input logic [19:0] a);
        if (ovr.exists(a)) return ovr[a];
        return a[15:0] ^ 16'h5A3C ^ {12'h000, a[19:16]};
    endfunction

    function automatic logic [19:0] exp_lin(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'b0000} + {4'b0000, o};
    endfunction

    // Memory responder: acknowledges after lat wait cycles and logs beat addresses.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (wait_cnt >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mdl(mem_addr);
                    if (log_n < 8) log_addr[log_n] = mem_addr;
                    log_n    = log_n + 1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt = wait_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) if (done) done_cnt = done_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic write_base(input logic [19:0] v);
        @(negedge clk); base_we = 1'b1; base_wdata = v;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic write_limit(input logic [15:0] v);
        @(negedge clk); limit_we = 1'b1; limit_wdata = v;
        @(negedge clk); limit_we = 1'b0;
    endtask

    // Issue one start and wait, at falling edges, for done or fault.
    task automatic fetch(input logic [7:0] v, output bit got_done, output bit got_fault);
        got_done = 0; got_fault = 0; log_n = 0; wait_cnt = 0;
        @(negedge clk); start = 1'b1; vector = v;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done)  begin got_done = 1;  break; end
            if (fault) begin got_fault = 1; break; end
            @(negedge clk);
        end
    endtask

    // Fetch a vector and compare every result against the table model.
    task automatic fetch_and_check(input logic [7:0] v, input logic [19:0] base, input string tag);
        bit gd, gf;
        logic [19:0] ea;
        logic [15:0] eo, es;
        ea = base + {10'd0, v, 2'b00};
        eo = mdl(ea);
        es = mdl(ea + 20'd2);
        fetch(v, gd, gf);
        chk({tag, " R4 done seen"}, {31'd0, gd}, 32'd1);
        chk({tag, " R2 first beat at entry"}, {12'd0, log_addr[0]}, {12'd0, ea});
        chk({tag, " R2 second beat at entry+2"}, {12'd0, log_addr[1]}, {12'd0, ea + 20'd2});
        chk({tag, " R2 beat count"}, log_n, 2);
        chk({tag, " R2 offset"}, {16'd0, hnd_offset}, {16'd0, eo});
        chk({tag, " R2 segment"}, {16'd0, hnd_segment}, {16'd0, es});
        chk({tag, " R3 linear"}, {12'd0, hnd_linear}, {12'd0, exp_lin(es, eo)});
        @(negedge clk);
        chk({tag, " R4 done drops"}, {31'd0, done}, 32'd0);
        chk({tag, " R4 outputs hold"}, {16'd0, hnd_offset}, {16'd0, eo});
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 fault", {31'd0, fault}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 segment", {16'd0, hnd_segment}, 0);
        chk("R1 offset", {16'd0, hnd_offset}, 0);
        chk("R1 linear", {12'd0, hnd_linear}, 0);
    endtask

    task automatic t_basic();
        lat = 0;
        fetch_and_check(8'h08, 20'h00000, "basic v08");
        lat = 3;
        fetch_and_check(8'h00, 20'h00000, "R1 first v00");
        fetch_and_check(8'hFF, 20'h00000, "R1 last vFF");
    endtask

    task automatic t_carry();
        lat = 1;
        ovr[20'h00100] = 16'hFFFF;
        ovr[20'h00102] = 16'hFFFF;
        fetch_and_check(8'h40, 20'h00000, "carry v40");
        chk("R3 carry dropped", {12'd0, hnd_linear}, 32'h0FFEF);
        ovr[20'h00104] = 16'h0010;
        ovr[20'h00106] = 16'h1234;
        fetch_and_check(8'h41, 20'h00000, "plain v41");
        chk("R3 linear 12350", {12'd0, hnd_linear}, 32'h12350);
    endtask

    task automatic t_latency();
        lat = 7;
        fetch_and_check(8'h21, 20'h00000, "R8 slow ack");
        lat = 0;
    endtask

    task automatic t_busy_ignore();
        bit gd, gf;
        logic [19:0] ea;
        lat = 6; log_n = 0; wait_cnt = 0;
        ea = {10'd0, 8'h30, 2'b00};
        done_cnt = 0;
        @(negedge clk); start = 1'b1; vector = 8'h30;
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1; vector = 8'h31;
        @(negedge clk); start = 1'b0;
        gd = 0; gf = 0;
        for (int i = 0; i < 60; i++) @(negedge clk);
        chk("R6 single done", done_cnt, 1);
        chk("R6 beat count", log_n, 2);
        chk("R6 kept first vector", {16'd0, hnd_offset}, {16'd0, mdl(ea)});
        chk("R6 idle after", {31'd0, busy}, 0);
        lat = 0;
    endtask

    task automatic t_reloc();
        bit gd, gf;
        logic [19:0] ea;
        write_base(20'h12340);
        fetch_and_check(8'h05, 20'h12340, "R7 relocated");
        write_base(20'hFFFF0);
        fetch_and_check(8'h08, 20'hFFFF0, "R2 address wrap");
        chk("R2 wrapped entry", {12'd0, log_addr[0]}, 32'h00010);
        // Base load while a fetch is in flight must not move that fetch.
        write_base(20'h00000);
        lat = 5; log_n = 0; wait_cnt = 0;
        ea = {10'd0, 8'h10, 2'b00};
        @(negedge clk); start = 1'b1; vector = 8'h10;
        @(negedge clk); start = 1'b0; base_we = 1'b1; base_wdata = 20'h40000;
        @(negedge clk); base_we = 1'b0;
        gd = 0;
        for (int i = 0; i < 60; i++) begin
            if (done) gd = 1;
            @(negedge clk);
        end
        chk("R7 in-flight done", {31'd0, gd}, 1);
        chk("R7 in-flight first beat", {12'd0, log_addr[0]}, {12'd0, ea});
        chk("R7 in-flight second beat", {12'd0, log_addr[1]}, {12'd0, ea + 20'd2});
        lat = 0;
        fetch_and_check(8'h01, 20'h40000, "R7 new base after");
        write_base(20'h00000);
    endtask

    task automatic t_limit();
        bit gd, gf;
        logic [15:0] held;
        write_limit(16'h003F);
        fetch_and_check(8'h0F, 20'h00000, "R5 last byte on limit");
        held = hnd_offset;
        done_cnt = 0;
        fetch(8'h10, gd, gf);
        chk("R5 fault raised", {31'd0, gf}, 1);
        @(negedge clk);
        chk("R5 fault one cycle", {31'd0, fault}, 0);
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk("R5 no request", log_n, 0);
        chk("R5 no done", done_cnt, 0);
        chk("R5 outputs held", {16'd0, hnd_offset}, {16'd0, held});
        write_limit(16'h03FF);
        fetch_and_check(8'h10, 20'h00000, "R5 limit restored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_carry();
        t_latency();
        t_busy_ignore();
        t_reloc();
        t_limit();
        repeat (4) @(negedge clk);
        report();
    end
endmodule